// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a logical page number into a final page descriptor by walking a three-level translation table held in ordinary memory. A requester presents the upper bits of a logical address together with the privilege mode of the access, whether the access is a write, and the current page size (4 KB or 8 KB). The walker takes the user or the supervisor table root, then reads a root-level descriptor, a pointer-level descriptor and a page-level descriptor. If the page-level entry is marked indirect, it makes one further read to reach the real entry.

The walker works through a single 32-bit memory port with a request/ready handshake and an error flag. It combines write protection from every level into the descriptor it returns. It also marks entries as used, and pages as modified, by writing them back to memory, but only when a bit actually has to change. The answer comes back as a one-cycle response carrying the descriptor and a fault flag. The requester uses it to fill a translation cache or to raise an access fault.

Top module: `pgwalk_top`

## Requirements
- R1: A walk starts in the idle state when `req_valid` is high. Its first memory read uses the supervisor root when `req_super` is 1 and the user root otherwise. The read address is the root with bits 8:0 cleared, ORed with logical bits 31:25 shifted left by 2.
- R2: The second read address is the root-level descriptor with bits 8:0 cleared, ORed with logical bits 24:18 shifted left by 2.
- R3: The third read address depends on the page size. With `page_8k`=0 it is the pointer-level descriptor with bits 7:0 cleared, ORed with logical bits 17:12 shifted left by 2. With `page_8k`=1 it is the pointer-level descriptor with bits 6:0 cleared, ORed with logical bits 17:13 shifted left by 2.
- R4: A root-level or pointer-level descriptor with bit 1 clear ends the walk at once. The response has fault=1 and descriptor 0, and no further memory access is made.
- R5: A page-level descriptor whose bits 1:0 equal 2'b10 is indirect. The walker reads the word at that descriptor with bits 1:0 cleared and treats that word as the page descriptor.
- R6: A page descriptor with bit 0 clear is not resident. It is returned unchanged with fault=1, and nothing is written back for it.
- R7: When bit 2 (write protect) is set in the root-level or pointer-level descriptor, bit 2 is set in the returned page descriptor.
- R8: A root-level or pointer-level descriptor with bit 3 (used) clear is written back once to its own address, with bit 3 set. If bit 3 is already set, nothing is written.
- R9: A write to a page whose effective bit 2 is clear sets bits 3 and 4 (used, modified) with a single write-back, made only if either bit was clear. Any other resident access sets only bit 3, and only if it was clear. The written word equals the returned descriptor.
- R10: A user-mode access (`req_super`=0) to a resident page whose bit 7 (supervisor only) is set returns fault=1. A supervisor access to the same kind of page does not fault.
- R11: A memory access that completes with `mem_err`=1 aborts the walk. The response follows in the next cycle with fault=1 and descriptor 0.
- R12: While `mem_req` is high and `mem_ready` is low, the request, address and direction hold steady. `req_ready` is high only when no walk is in progress, and `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, able to accept a walk |
| req_lpage | input | 20 | Logical address bits 31:12 |
| req_super | input | 1 | Supervisor-mode access |
| req_write | input | 1 | Write access |
| page_8k | input | 1 | 1 = 8 KB pages, 0 = 4 KB pages |
| user_root | input | 32 | User table root pointer |
| super_root | input | 32 | Supervisor table root pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Access completed with an error |
| rsp_valid | output | 1 | Response pulse |
| rsp_desc | output | 32 | Final page descriptor |
| rsp_fault | output | 1 | Walk ended in a fault |

## Verification
The bench goes after several corner cases, and each one shows up in a specific way. A walker that used the 4 KB index mask on 8 KB pages would read the wrong page-table word and return a different descriptor. A walker that wrote back an entry whose used bit was already set would show an extra access in the per-walk access count. The bench also covers invalid entries at the root and pointer levels, the single indirect hop, non-resident pages, write protection inherited from an upper level, and user accesses to supervisor-only pages. If any of these were handled wrongly, the returned descriptor, the fault flag, the number of memory accesses or the words left in memory would differ from the model. A memory error injected part way through a walk must abort it without any further access.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int B_RES    = 0;   // page entry resident
    localparam int B_TVALID = 1;   // table entry valid
    localparam int B_WP     = 2;   // write protect
    localparam int B_USED   = 3;   // used (referenced)
    localparam int B_MOD    = 4;   // modified (dirty)
    localparam int B_SUP    = 7;   // supervisor only

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ROOT  = 3'd1,
        ST_PTR   = 3'd2,
        ST_PAGE  = 3'd3,
        ST_INDIR = 3'd4,
        ST_WB    = 3'd5,
        ST_DONE  = 3'd6
    } walk_st_e;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int ADDR_W = 32,
    parameter int PG_LSB = 12
) (
    input  logic [ADDR_W-PG_LSB-1:0] lpn,
    input  logic [ADDR_W-1:0]        root_ptr,
    input  logic [ADDR_W-1:0]        tbl_desc,
    input  logic                     big_page,
    output logic [ADDR_W-1:0]        root_a,
    output logic [ADDR_W-1:0]        ptr_a,
    output logic [ADDR_W-1:0]        page_a
);
    localparam int LW      = ADDR_W - PG_LSB;
    localparam int TBL_LSB = 9;   // root and pointer tables are 512-byte aligned
    localparam int PG4_LSB = 8;   // 64-entry page table
    localparam int PG8_LSB = 7;   // 32-entry page table

    logic [ADDR_W-1:0] page4_a;
    logic [ADDR_W-1:0] page8_a;
    logic              unused_bits;

    assign root_a  = {root_ptr[ADDR_W-1:TBL_LSB], lpn[LW-1:LW-7], 2'b00};
    assign ptr_a   = {tbl_desc[ADDR_W-1:TBL_LSB], lpn[LW-8:LW-14], 2'b00};
    assign page4_a = {tbl_desc[ADDR_W-1:PG4_LSB], lpn[5:0], 2'b00};
    assign page8_a = {tbl_desc[ADDR_W-1:PG8_LSB], lpn[5:1], 2'b00};
    assign page_a  = big_page ? page8_a : page4_a;

    assign unused_bits = ^{root_ptr[TBL_LSB-1:0], tbl_desc[PG8_LSB-1:0]};

endmodule

// File: rtl/pgwalk_mark.sv
module pgwalk_mark
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] raw,
    input  logic              wp_acc,
    input  logic              is_write,
    input  logic              is_super,
    output logic [ADDR_W-1:0] upd,
    output logic              need_wb,
    output logic              fault
);
    logic [ADDR_W-1:0] merged;

    always_comb begin
        merged        = raw;
        merged[B_WP]  = raw[B_WP] | wp_acc;
        upd           = merged;
        need_wb       = 1'b0;
        fault         = 1'b0;
        if (!raw[B_RES]) begin
            upd   = raw;
            fault = 1'b1;
        end else begin
            fault = !is_super && merged[B_SUP];
            if (is_write && !merged[B_WP]) begin
                need_wb     = !(merged[B_USED] && merged[B_MOD]);
                upd[B_USED] = 1'b1;
                upd[B_MOD]  = 1'b1;
            end else begin
                need_wb     = !merged[B_USED];
                upd[B_USED] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PG_LSB = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-PG_LSB-1:0] req_lpage,
    input  logic                     req_super,
    input  logic                     req_write,
    input  logic                     page_8k,
    input  logic [ADDR_W-1:0]        user_root,
    input  logic [ADDR_W-1:0]        super_root,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [ADDR_W-1:0]        mem_wdata,
    input  logic                     mem_ready,
    input  logic [ADDR_W-1:0]        mem_rdata,
    input  logic                     mem_err,
    output logic                     rsp_valid,
    output logic [ADDR_W-1:0]        rsp_desc,
    output logic                     rsp_fault
);
    localparam int LW = ADDR_W - PG_LSB;

    typedef struct packed {
        walk_st_e          st;
        walk_st_e          ret;
        logic [LW-1:0]     lpn;
        logic              sup;
        logic              wr;
        logic              big;
        logic              wp;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] wdata;
        logic [ADDR_W-1:0] desc;
        logic              fault;
    } walk_s;

    walk_s q, d;

    logic [LW-1:0]     va_sel;
    logic [ADDR_W-1:0] root_sel;
    logic [ADDR_W-1:0] root_a, ptr_a, page_a;
    logic [ADDR_W-1:0] mk_desc;
    logic              mk_wb, mk_fault;
    walk_st_e          nxt_st;
    logic [ADDR_W-1:0] nxt_a;

    assign va_sel   = (q.st == ST_IDLE) ? req_lpage : q.lpn;
    assign root_sel = req_super ? super_root : user_root;

    pgwalk_addr #(.ADDR_W(ADDR_W), .PG_LSB(PG_LSB)) addr_i (
        .lpn      (va_sel),
        .root_ptr (root_sel),
        .tbl_desc (mem_rdata),
        .big_page (q.big),
        .root_a   (root_a),
        .ptr_a    (ptr_a),
        .page_a   (page_a)
    );

    pgwalk_mark #(.ADDR_W(ADDR_W)) mark_i (
        .raw      (mem_rdata),
        .wp_acc   (q.wp),
        .is_write (q.wr),
        .is_super (q.sup),
        .upd      (mk_desc),
        .need_wb  (mk_wb),
        .fault    (mk_fault)
    );

    always_comb begin
        d      = q;
        nxt_st = (q.st == ST_ROOT) ? ST_PTR : ST_PAGE;
        nxt_a  = (q.st == ST_ROOT) ? ptr_a : page_a;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.lpn   = req_lpage;
                    d.sup   = req_super;
                    d.wr    = req_write;
                    d.big   = page_8k;
                    d.wp    = 1'b0;
                    d.fault = 1'b0;
                    d.desc  = '0;
                    d.addr  = root_a;
                    d.st    = ST_ROOT;
                end
            end
            ST_ROOT, ST_PTR: begin
                if (mem_ready) begin
                    if (mem_err || !mem_rdata[B_TVALID]) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                        d.desc  = '0;
                    end else begin
                        d.wp = q.wp | mem_rdata[B_WP];
                        if (!mem_rdata[B_USED]) begin
                            d.st           = ST_WB;
                            d.wdata        = mem_rdata;
                            d.wdata[B_USED] = 1'b1;
                            d.ret          = nxt_st;
                            d.nxt          = nxt_a;
                        end else begin
                            d.st   = nxt_st;
                            d.addr = nxt_a;
                        end
                    end
                end
            end
            ST_PAGE, ST_INDIR: begin
                if (mem_ready) begin
                    if (mem_err) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                        d.desc  = '0;
                    end else if (q.st == ST_PAGE && mem_rdata[1:0] == 2'b10) begin
                        d.st   = ST_INDIR;
                        d.addr = {mem_rdata[ADDR_W-1:2], 2'b00};
                    end else begin
                        d.desc  = mk_desc;
                        d.fault = mk_fault;
                        if (mk_wb) begin
                            d.st    = ST_WB;
                            d.wdata = mk_desc;
                            d.ret   = ST_DONE;
                        end else begin
                            d.st = ST_DONE;
                        end
                    end
                end
            end
            ST_WB: begin
                if (mem_ready) begin
                    if (mem_err) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                        d.desc  = '0;
                    end else begin
                        d.st   = q.ret;
                        d.addr = q.nxt;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign mem_req   = (q.st == ST_ROOT) || (q.st == ST_PTR) || (q.st == ST_PAGE) ||
                       (q.st == ST_INDIR) || (q.st == ST_WB);
    assign mem_we    = (q.st == ST_WB);
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign rsp_valid = (q.st == ST_DONE);
    assign rsp_desc  = q.desc;
    assign rsp_fault = q.fault;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_super,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              mem_err,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_desc,
    input logic              rsp_fault
);
    logic sup_seen;
    logic unused_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sup_seen <= 1'b0;
        else if (req_valid && req_ready) sup_seen <= req_super;
    end

    assign unused_bits = ^{mem_wdata, rsp_desc};

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !rsp_valid); // R12
    AST_WB_USED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[3]); // R8
    AST_USER_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !sup_seen && rsp_desc[0] && rsp_desc[7] |-> rsp_fault); // R10
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && mem_err |=> rsp_valid && rsp_fault && (rsp_desc == '0)); // R11

endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_super (req_super),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .rsp_valid (rsp_valid),
    .rsp_desc  (rsp_desc),
    .rsp_fault (rsp_fault)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_lpage = '0;
    logic        req_super = 1'b0;
    logic        req_write = 1'b0;
    logic        page_8k = 1'b0;
    logic [31:0] user_root  = 32'h0001_0000;
    logic [31:0] super_root = 32'h0002_0000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_desc;

    always #2 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lpage(req_lpage), .req_super(req_super), .req_write(req_write),
        .page_8k(page_8k), .user_root(user_root), .super_root(super_root),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rsp_valid(rsp_valid), .rsp_desc(rsp_desc), .rsp_fault(rsp_fault)
    );

    int errors = 0;
    int checks = 0;
    bit all_done = 1'b0;

    logic [31:0] mem     [logic [31:0]];
    logic [31:0] exp_mem [logic [31:0]];
    logic [31:0] touch_q [$];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          lat = 0;
    int          wcnt = 0;
    int          acc_cnt = 0;

    typedef struct {
        logic [31:0] desc;
        logic        fault;
        int          n;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_dut(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] rd_exp(logic [31:0] a);
        if (exp_mem.exists(a)) return exp_mem[a];
        return 32'h0;
    endfunction

    task automatic put(logic [31:0] a, logic [31:0] v);
        mem[a] = v;
        exp_mem[a] = v;
    endtask

    function automatic logic [31:0] a_root(logic [31:0] va, bit sup);
        logic [31:0] r = sup ? super_root : user_root;
        return {r[31:9], 9'd0} | {23'd0, va[31:25], 2'b00};
    endfunction
    function automatic logic [31:0] a_ptr(logic [31:0] t, logic [31:0] va);
        return {t[31:9], 9'd0} | {23'd0, va[24:18], 2'b00};
    endfunction
    function automatic logic [31:0] a_page(logic [31:0] t, logic [31:0] va, bit big);
        if (big) return {t[31:7], 7'd0} | {25'd0, va[17:13], 2'b00};
        return {t[31:8], 8'd0} | {24'd0, va[17:12], 2'b00};
    endfunction

    task automatic setup(logic [31:0] va, bit sup, bit big,
                         logic [31:0] rd, logic [31:0] pd, logic [31:0] gd);
        put(a_root(va, sup), rd);
        put(a_ptr(rd, va), pd);
        put(a_page(pd, va, big), gd);
    endtask

    // Expected result of one walk, derived from the requirements.
    task automatic ref_walk(logic [31:0] va, bit sup, bit wr, bit big, output exp_t e);
        logic [31:0] a, t, p;
        bit wp = 0;
        touch_q.delete();
        e.n = 0; e.fault = 1'b1; e.desc = 32'h0;
        a = a_root(va, sup);                       // R1
        for (int lvl = 0; lvl < 2; lvl++) begin
            e.n++;
            if (a == err_addr) return;             // R11
            t = rd_exp(a);
            if (!t[1]) return;                     // R4
            wp = wp | t[2];                        // R7
            if (!t[3]) begin                       // R8
                exp_mem[a] = t | 32'h8; touch_q.push_back(a); e.n++;
            end
            a = (lvl == 0) ? a_ptr(t, va) : a_page(t, va, big); // R2 R3
        end
        e.n++;
        if (a == err_addr) return;
        p = rd_exp(a);
        if (p[1:0] == 2'b10) begin                 // R5
            a = {p[31:2], 2'b00};
            e.n++;
            if (a == err_addr) return;
            p = rd_exp(a);
        end
        if (!p[0]) begin e.desc = p; return; end   // R6
        if (wp) p[2] = 1'b1;
        if (wr && !p[2]) begin                     // R9
            if (p[4:3] != 2'b11) begin
                p = p | 32'h18; exp_mem[a] = p; touch_q.push_back(a); e.n++;
            end
        end else if (!p[3]) begin
            p = p | 32'h8; exp_mem[a] = p; touch_q.push_back(a); e.n++;
        end
        e.desc  = p;
        e.fault = !sup && p[7];                    // R10
    endtask

    task automatic walk(string tag, logic [31:0] va, bit sup, bit wr, bit big);
        exp_t e;
        ref_walk(va, sup, wr, big, e);
        e.tag = tag;
        @(negedge clk);
        acc_cnt = 0;
        exp_q.push_back(e);
        req_lpage = va[31:12]; req_super = sup; req_write = wr; page_8k = big;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R12 busy"}, {31'd0, req_ready}, 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Memory model: grants after lat idle cycles, applies writes on the grant.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
            wcnt      = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                acc_cnt++;
                mem_err   = (mem_addr == err_addr);
                mem_rdata = rd_dut(mem_addr);
                if (mem_we && !mem_err) mem[mem_addr] = mem_wdata;
            end else begin
                wcnt++;
            end
        end
    end

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q[0];
                chk({e.tag, " desc"}, rsp_desc, e.desc);
                chk({e.tag, " fault"}, {31'd0, rsp_fault}, {31'd0, e.fault});
                chk({e.tag, " accesses"}, acc_cnt, e.n);
                foreach (touch_q[i])
                    chk({e.tag, " memory word"}, rd_dut(touch_q[i]), rd_exp(touch_q[i]));
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!all_done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // R1 R2 R3 R8 R9: fresh tables, used bits all clear, user read 4 KB
        lat = 0;
        setup(32'h1234_5678, 0, 0, 32'h0003_0002, 32'h0004_0002, 32'h0080_0001);
        walk("R1 R2 R3 R8 R9 first walk", 32'h1234_5678, 0, 0, 0);
        // R8 R9: used bits now set, no write-back expected
        walk("R8 R9 repeat walk", 32'h1234_5678, 0, 0, 0);

        // R1 R3: supervisor root, 8 KB page, page mask keeps bit 7
        lat = 2;
        setup(32'hA5C3_E000, 1, 1, 32'h0005_000A, 32'h0006_008A, 32'h00A0_0089);
        walk("R1 R3 supervisor 8k", 32'hA5C3_E000, 1, 0, 1);

        // R4: invalid root-level and pointer-level entries
        put(a_root(32'h4000_0000, 0), 32'h0007_0000);
        walk("R4 root invalid", 32'h4000_0000, 0, 0, 0);
        setup(32'h4400_0000, 0, 0, 32'h0007_800A, 32'h0000_0008, 32'h0000_0001);
        walk("R4 pointer invalid", 32'h4400_0000, 0, 0, 0);

        // R5: indirect page entry
        lat = 1;
        setup(32'h0800_3000, 0, 0, 32'h0008_000A, 32'h0009_000A, 32'h000A_1232);
        put(32'h000A_1230, 32'h00B0_0009);
        walk("R5 indirect", 32'h0800_3000, 0, 0, 0);

        // R6: non-resident page returned as is
        setup(32'h0C00_0000, 0, 0, 32'h000B_000A, 32'h000C_000A, 32'h1234_5000);
        walk("R6 not resident", 32'h0C00_0000, 0, 0, 0);

        // R7 R9: protection inherited from pointer level, write sets only used
        lat = 0;
        setup(32'h1000_1000, 0, 0, 32'h000D_000A, 32'h000E_000E, 32'h00C0_0001);
        walk("R7 R9 protected write", 32'h1000_1000, 0, 1, 0);

        // R9: unprotected write sets modified; second write needs no write-back
        setup(32'h1400_2000, 0, 0, 32'h000F_000A, 32'h0010_000A, 32'h00D0_0009);
        walk("R9 unprotected write", 32'h1400_2000, 0, 1, 0);
        walk("R9 write already marked", 32'h1400_2000, 0, 1, 0);

        // R10: supervisor-only page, user then supervisor
        setup(32'h1800_0000, 0, 0, 32'h0011_000A, 32'h0012_000A, 32'h00E0_0089);
        walk("R10 user to supervisor page", 32'h1800_0000, 0, 0, 0);
        setup(32'h1800_0000, 1, 0, 32'h0013_000A, 32'h0014_000A, 32'h00E0_0089);
        walk("R10 supervisor access", 32'h1800_0000, 1, 0, 0);

        // R11: memory error on the pointer-level fetch
        lat = 1;
        setup(32'h1C00_0000, 0, 0, 32'h0015_000A, 32'h0016_000A, 32'h00F0_0009);
        err_addr = a_ptr(32'h0015_000A, 32'h1C00_0000);
        walk("R11 memory error", 32'h1C00_0000, 0, 0, 0);
        err_addr = 32'hFFFF_FFFF;

        repeat (4) @(negedge clk);
        all_done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule